// File: doc/BRIEF.md
# Linear Burst Synchronous SRAM Core

This block is a behavioural model of a synchronous SRAM that moves data in linear bursts of four words and stores them in two equal banks. The host starts a burst by pulsing `start` with a full address and a direction. That start beat accesses the given address. Each later cycle with `step` high is one more beat. On these beats the two low address bits advance by one, modulo four, and stay inside their aligned group of four words. All higher address bits stay fixed. After the fourth beat the burst is finished, and further steps do nothing until the next start.

The most significant address bit picks the bank. A low value enables the lower bank and a high value enables the upper bank, so the block holds twice the words of one bank at the same data width. Writes take their data and per-lane enables on the beat. Reads return the word one cycle after the beat, with `rd_valid` high in that cycle.

The sequencer has three states. `ST_IDLE` is entered at reset and after the last beat of a burst. `ST_WRITE` and `ST_READ` are the active burst states. The transitions are:
- start: any state goes to `ST_WRITE` or `ST_READ`, following `wr_sel`.
- step: an active state stays in that state and advances the beat.
- finish: on the fourth beat the active state returns to `ST_IDLE`.

Top module: `lsram_burst_core`

## Requirements
- R1: After reset `rd_valid` is 0 and `rd_data` is 0. A `step` pulse with no burst open causes no access, so `rd_valid` stays 0.
- R2: A cycle with `start` high is itself a beat. It accesses exactly the address on `addr`, and it writes if `wr_sel` is 1 or reads if `wr_sel` is 0.
- R3: Each `step` beat of an open burst accesses the previous beat's address with bits [1:0] incremented by one modulo 4, so a start of 01 gives 01, 10, 11, 00.
- R4: Address bits above bit 1, the bank bit included, keep their start value for the whole burst. A burst that starts at x11 wraps to x00 of the same group.
- R5: A burst has four beats: the start beat and three steps. A step after the fourth beat neither writes nor produces `rd_valid`.
- R6: `start` restarts the burst from the new `addr`, even when a burst is open and `step` is high in the same cycle.
- R7: `addr[7]` selects the bank. When it is 0 only the lower bank is accessed, and when it is 1 only the upper bank is accessed. The same low address in the two banks holds separate words.
- R8: A read beat gives `rd_valid` = 1 and the addressed word on `rd_data` in the next cycle. `rd_valid` is 0 after any cycle without a read beat.
- R9: `lane_we[i]` gates bits [9i+8:9i] of `wr_data` on a write beat. Lanes whose enable is 0 keep their stored value.
- R10: A write burst of 100, 101, 102, 103 that starts at 01, followed by a read burst that starts at 11, returns 102, 103, 100, 101.
- R11: Cycles without `step` inside an open burst are not beats. The counter holds, and the next step continues the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Open a burst at `addr` (this cycle is a beat) |
| wr_sel | input | 1 | Direction of the burst opened by `start`: 1 write, 0 read |
| step | input | 1 | Advance the open burst by one beat |
| addr | input | ADDR_W (8) | Start address; MSB is bank select |
| lane_we | input | LANES (4) | Per-lane write enable for the current beat |
| wr_data | input | LANES*LANE_W (36) | Write data for the current beat |
| rd_data | output | LANES*LANE_W (36) | Read word, valid one cycle after a read beat |
| rd_valid | output | 1 | `rd_data` carries a read result |

## Verification
The bench uses the values 100 to 103 to check the write-at-01, read-at-11 ordering. A counter that did not wrap, or that carried into bit 2, would return the wrong words or unwritten ones. An extra step after the fourth write beat would overwrite address 01 in a block that does not stop the burst, and the bench's later read of 01 would show this. Bursts in the upper bank at the same low addresses would corrupt lower-bank data if the bank select were ignored. A start raised together with a step mid-burst checks that the reload wins over the step. A partial-lane write catches enables that are shifted or ignored.

// File: rtl/lsram_pkg.sv
package lsram_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WRITE = 2'd1,
        ST_READ  = 2'd2
    } burst_state_e;

    localparam int BEATS_PER_BURST = 4;
endpackage

// File: rtl/lsram_burst_seq.sv
module lsram_burst_seq
    import lsram_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              wr_sel,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr,
    output logic              beat_valid,
    output logic              beat_wr,
    output logic [ADDR_W-1:0] beat_addr
);
    burst_state_e          state_q, state_d;
    logic [ADDR_W-1:2]     base_q, base_d;
    logic [1:0]            cnt_q, cnt_d;
    logic [1:0]            left_q, left_d;
    logic                  active;

    assign active = (state_q != ST_IDLE);

    // next-state process
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        if (start) begin
            state_d = wr_sel ? ST_WRITE : ST_READ;
            base_d  = addr[ADDR_W-1:2];
            cnt_d   = addr[1:0];
            left_d  = 2'(BEATS_PER_BURST - 1);
        end else if (active && step) begin
            cnt_d  = cnt_q + 2'd1;
            left_d = left_q - 2'd1;
            if (left_q == 2'd1) begin
                state_d = ST_IDLE;
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
            cnt_q   <= 2'd0;
            left_q  <= 2'd0;
        end else begin
            state_q <= state_d;
            base_q  <= base_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
        end
    end

    // beat outputs
    always_comb begin
        beat_valid = 1'b0;
        beat_wr    = 1'b0;
        beat_addr  = addr;
        if (start) begin
            beat_valid = 1'b1;
            beat_wr    = wr_sel;
            beat_addr  = addr;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    beat_valid = 1'b0;
                end
                ST_WRITE: begin
                    beat_valid = step;
                    beat_wr    = 1'b1;
                    beat_addr  = {base_q, cnt_q + 2'd1};
                end
                ST_READ: begin
                    beat_valid = step;
                    beat_wr    = 1'b0;
                    beat_addr  = {base_q, cnt_q + 2'd1};
                end
                default: beat_valid = 1'b0;
            endcase
        end
    end

    p_wrap_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !start) |=> (cnt_q == 2'($past(cnt_q) + 2'd1)));

    p_upper_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !start) |=> $stable(base_q));

    p_four_beats_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (active && step && !start && left_q == 2'd1) |=> (state_q == ST_IDLE));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |-> !beat_valid);

    p_start_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == $past(addr[1:0]) && state_q != ST_IDLE));
endmodule

// File: rtl/lsram_bank.sv
module lsram_bank #(
    parameter int WORD_AW = 7,
    parameter int LANES   = 4,
    parameter int LANE_W  = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    wr,
    input  logic [WORD_AW-1:0]      addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata
);
    localparam int DEPTH = 1 << WORD_AW;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] cells [DEPTH];
        logic [LANE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (en && wr && lane_we[g]) begin
                cells[addr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= '0;
            end else if (en && !wr) begin
                q <= cells[addr];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = q;
    end
endmodule

// File: rtl/lsram_burst_core.sv
module lsram_burst_core #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    wr_sel,
    input  logic                    step,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wr_data,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DATA_W  = LANES * LANE_W;
    localparam int WORD_AW = ADDR_W - 1;
    localparam int NBANK   = 2;

    logic              beat_valid;
    logic              beat_wr;
    logic [ADDR_W-1:0] beat_addr;
    logic [NBANK-1:0]  bank_en;
    logic [DATA_W-1:0] bank_q [NBANK];
    logic              rd_bank_q;

    lsram_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .wr_sel     (wr_sel),
        .step       (step),
        .addr       (addr),
        .beat_valid (beat_valid),
        .beat_wr    (beat_wr),
        .beat_addr  (beat_addr)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign bank_en[b] = beat_valid && (beat_addr[ADDR_W-1] == 1'(b));

        lsram_bank #(
            .WORD_AW (WORD_AW),
            .LANES   (LANES),
            .LANE_W  (LANE_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (bank_en[b]),
            .wr      (beat_wr),
            .addr    (beat_addr[WORD_AW-1:0]),
            .lane_we (lane_we),
            .wdata   (wr_data),
            .rdata   (bank_q[b])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid  <= 1'b0;
            rd_bank_q <= 1'b0;
        end else begin
            rd_valid <= beat_valid && !beat_wr;
            if (beat_valid && !beat_wr) begin
                rd_bank_q <= beat_addr[ADDR_W-1];
            end
        end
    end

    assign rd_data = rd_bank_q ? bank_q[1] : bank_q[0];

    p_one_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_en));

    p_bank_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && beat_addr[ADDR_W-1]) |-> (bank_en == 2'b10));

    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (beat_valid && !beat_wr) |=> rd_valid);

    p_no_spurious_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(beat_valid && !beat_wr) |=> !rd_valid);
endmodule

// File: tb/tb_lsram_burst_core.sv
module tb_lsram_burst_core;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        start, wr_sel, step;
    logic [7:0]  addr;
    logic [3:0]  lane_we;
    logic [35:0] wr_data;
    logic [35:0] rd_data;
    logic        rd_valid;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lsram_burst_core dut (
        .clk(clk), .rst_n(rst_n), .start(start), .wr_sel(wr_sel), .step(step),
        .addr(addr), .lane_we(lane_we), .wr_data(wr_data),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    typedef struct packed {
        logic        ld;
        logic        wr;
        logic        adv;
        logic [7:0]  a;
        logic [3:0]  we;
        logic [35:0] wd;
        logic        ev;
        logic [35:0] ed;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VEC [NV] = '{
        '{1'b1,1'b1,1'b0,8'h01,4'hF,36'd100,1'b0,36'd0,4'd2},  // R2 write start at 01
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd101,1'b0,36'd0,4'd3},  // R3 -> 10
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd102,1'b0,36'd0,4'd3},  // R3 -> 11
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd103,1'b0,36'd0,4'd3},  // R3 -> 00
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd999,1'b0,36'd0,4'd5},  // R5 fifth step ignored
        '{1'b1,1'b0,1'b0,8'h03,4'h0,36'd0,1'b1,36'd102,4'd10}, // R10 read at 11
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd103,4'd4},  // R4 wrap to 00 of group
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd100,4'd10}, // R10 (and R5: 01 kept)
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd101,4'd10}, // R10
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b0,36'd0,4'd5},    // R5 read burst ended
        '{1'b0,1'b0,1'b0,8'h00,4'h0,36'd0,1'b0,36'd0,4'd11},   // R11 idle cycle
        '{1'b1,1'b1,1'b0,8'h82,4'hF,36'd200,1'b0,36'd0,4'd7},  // R7 upper bank write
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd201,1'b0,36'd0,4'd7},
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd202,1'b0,36'd0,4'd7},
        '{1'b0,1'b0,1'b1,8'h00,4'hF,36'd203,1'b0,36'd0,4'd7},
        '{1'b1,1'b0,1'b0,8'h00,4'h0,36'd0,1'b1,36'd103,4'd7},  // R7 lower bank intact
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd100,4'd8},  // R8
        '{1'b1,1'b0,1'b1,8'h80,4'h0,36'd0,1'b1,36'd202,4'd6},  // R6 restart, bank switch
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd203,4'd6},
        '{1'b0,1'b0,1'b0,8'h00,4'h0,36'd0,1'b0,36'd0,4'd11},   // R11 gap inside burst
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd200,4'd11},
        '{1'b0,1'b0,1'b1,8'h00,4'h0,36'd0,1'b1,36'd201,4'd3},
        '{1'b1,1'b1,1'b0,8'h10,4'hF,36'd0,1'b0,36'd0,4'd9},    // R9 clear word
        '{1'b1,1'b1,1'b0,8'h10,4'h5,36'hFFFFFFFFF,1'b0,36'd0,4'd9}, // R9 lanes 0,2
        '{1'b1,1'b0,1'b0,8'h10,4'h0,36'd0,1'b1,36'h007FC01FF,4'd9},
        '{1'b0,1'b0,1'b0,8'h00,4'h0,36'd0,1'b0,36'd0,4'd8}     // R8 valid drops
    };

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic l, input logic w, input logic s,
                         input logic [7:0] a, input logic [3:0] we, input logic [35:0] d);
        start = l; wr_sel = w; step = s; addr = a; lane_we = we; wr_data = d;
    endtask

    initial begin
        drive(1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 36'd0);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 rd_valid in reset", {35'd0, rd_valid}, 36'd0);
        check("R1 rd_data in reset", rd_data, 36'd0);
        rst_n = 1'b1;
        // R1: step with no open burst
        drive(1'b0, 1'b0, 1'b1, 8'h00, 4'hF, 36'd7);
        @(negedge clk);
        check("R1 stray step", {35'd0, rd_valid}, 36'd0);
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].ld, VEC[i].wr, VEC[i].adv, VEC[i].a, VEC[i].we, VEC[i].wd);
            @(negedge clk);
            check($sformatf("R%0d row %0d valid", VEC[i].rq, i), {35'd0, rd_valid}, {35'd0, VEC[i].ev});
            if (VEC[i].ev) begin
                check($sformatf("R%0d row %0d data", VEC[i].rq, i), rd_data, VEC[i].ed);
            end
        end
        // R2: single-beat read of the start address in the upper bank
        drive(1'b1, 1'b0, 1'b0, 8'h83, 4'h0, 36'd0);
        @(negedge clk);
        check("R2 start beat read", rd_data, 36'd201);
        drive(1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 36'd0);
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule